// File: doc/BRIEF.md
# Multi-configuration LRU cache miss profiler

This block watches a stream of memory addresses. For each address it works out, in one pass, whether a whole family of caches would miss. Every cache in the family uses the same line size. The caches differ in two ways: the number of sets, which is a power of two between 2^MMIN and 2^MMAX, and the number of ways, which is a power of two from 1 to AMAX. Each set-count level keeps one recency stack of tags per set, with the most recently used tag at the top. A single tag lookup gives the depth at which the tag is found. Every associativity that holds that depth or more would hit, and every smaller associativity would miss. This result is exact for least-recently-used replacement, because an LRU cache with N ways holds exactly the top N entries of the stack.

A trace source offers addresses on a valid/ready input. The block spends one clock per set-count level on each address. A separate combinational read port returns any of the saturating miss counters. A synchronous clear empties every stack and zeroes every counter, so a new trace can start.

Top module: `lru_miss_profiler`

## Requirements
- R1: After reset, `addr_ready_o` is 1 and every miss counter reads 0.
- R2: An address is accepted in a cycle in which `addr_valid_i` and `addr_ready_o` are both 1 and `clr_i` is 0. After acceptance, `addr_ready_o` is 0 for exactly LEVELS (MMAX-MMIN+1, which is 3 by default) cycles and then returns to 1. When it returns to 1, the counters include that address.
- R3: The line address is `addr_i >> OFS`. Level k, for k from 0 to LEVELS-1, uses the low k+MMIN bits of the line address as its set index and the bits above them as its tag. Counter (k, j) equals the miss count of an LRU cache with 2^(k+MMIN) sets and 2^j ways over the accepted trace.
- R4: Invalid entries never match. After reset or clear, the first access to a set misses at every associativity of that level.
- R5: A hit found at 1-based stack depth s increments only the counters of that level whose way count is below s. The hit entry then moves to the top, and the entries above it move down one place. Repeating an address straight away increments no counter.
- R6: On a miss, the least recently used entry of the set is replaced by the new tag, marked valid and placed at the top. All associativity counters of that level increment.
- R7: Counters are CNT_W bits wide. Each counter saturates at 2^CNT_W-1 and holds that value on further misses.
- R8: A cycle with `clr_i` high invalidates all entries, zeroes all counters and abandons any address in progress, so `addr_ready_o` is 1 in the next cycle. An address offered in the same cycle as the clear is dropped.
- R9: Addresses that differ only in their low OFS bits belong to the same line, so only the first of them can miss.
- R10: `rd_count_o` shows counter (`rd_level_i`, `rd_assoc_i`) combinationally, where `rd_assoc_i` is log2 of the way count. An index with level ≥ LEVELS or assoc ≥ log2(AMAX)+1 reads 0.
- R11: Within a level, the counter for 2^(j+1) ways never exceeds the counter for 2^j ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of stacks and counters |
| addr_valid_i | input | 1 | Trace address valid |
| addr_i | input | ADDR_W | Trace address |
| addr_ready_o | output | 1 | Block can accept an address |
| rd_level_i | input | LVL_W | Set-count level of the counter to read |
| rd_assoc_i | input | ASC_W | log2 of the way count of the counter to read |
| rd_count_o | output | CNT_W | Selected miss counter |

## Verification
The bench keeps its own model: one cache per set count and way count, each using age-stamp LRU, which is a different method from the shared recency stack in the block. It compares all nine counters against this model over directed stride-conflict patterns, dense pseudo-random traffic and wide random addresses. These runs catch an off-by-one in the hit-depth threshold, which would miscount exactly the cases where a hit lands at the 2-way or 4-way depth. They also catch a wrong index or tag slice at a deeper level, which would make that level's counts disagree with the model. Clearing is checked in three situations: an address re-accessed after a clear must miss again, a clear arriving while an address is in progress must leave the block idle and zeroed, and an address offered in the same cycle as a clear must be dropped. A second instance with a narrow counter and a line offset checks two things: a counter that wraps instead of saturating would show a small value, and an offset that is ignored would count extra misses inside one line.

// File: rtl/lru_prof_pkg.sv
package lru_prof_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } prof_state_e;
endpackage

// File: rtl/lru_seq.sv
module lru_seq
  import lru_prof_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int AW     = 16,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              valid_i,
  input  logic [AW-1:0]     line_i,
  output logic              ready_o,
  output logic [AW-1:0]     line_o,
  output logic [LEVELS-1:0] lvl_en_o
);

  prof_state_e      state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [AW-1:0]    line_q;
  logic             accept;

  assign ready_o = (state_q == ST_IDLE);
  assign accept  = valid_i & ready_o & ~clr_i;
  assign line_o  = line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
      line_q  <= '0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      lvl_q   <= '0;
    end else if (accept) begin
      state_q <= ST_BUSY;
      lvl_q   <= '0;
      line_q  <= line_i;
    end else if (state_q == ST_BUSY) begin
      if (int'(lvl_q) == LEVELS - 1) begin
        state_q <= ST_IDLE;
        lvl_q   <= '0;
      end else begin
        lvl_q <= lvl_q + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_en
    assign lvl_en_o[k] = (state_q == ST_BUSY) && (int'(lvl_q) == k);
  end

  // R2
  accept_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !ready_o);

  // R2
  ready_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_en_o[LEVELS-1] && !clr_i) |=> ready_o);

  // R8
  clr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ready_o);

  // R2
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> $stable(line_q));

endmodule

// File: rtl/lru_level.sv
module lru_level #(
  parameter int AW   = 16,
  parameter int LVL  = 0,
  parameter int MMIN = 1,
  parameter int AMAX = 4,
  localparam int POS_W = $clog2(AMAX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [AW-1:0]    line_i,
  output logic             hit_o,
  output logic [POS_W-1:0] pos_o
);

  localparam int IDX_W = LVL + MMIN;
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = AW - IDX_W;

  logic [TAG_W-1:0] tag_q [SETS][AMAX];
  logic [AMAX-1:0]  vld_q [SETS];

  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] tag;
  logic             hit;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] rpl;

  assign set_idx = line_i[IDX_W-1:0];
  assign tag     = line_i[AW-1:IDX_W];

  // first (most recent) valid match wins
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = AMAX - 1; p >= 0; p--) begin
      if (vld_q[set_idx][p] && (tag_q[set_idx][p] == tag)) begin
        hit = 1'b1;
        pos = POS_W'(p);
      end
    end
  end

  assign rpl   = hit ? pos : POS_W'(AMAX - 1);
  assign hit_o = hit;
  assign pos_o = pos;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int p = 0; p < AMAX; p++) tag_q[s][p] <= '0;
      end
    end else if (clr_i) begin
      for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
    end else if (en_i) begin
      for (int p = 1; p < AMAX; p++) begin
        if (p <= int'(rpl)) begin
          tag_q[set_idx][p] <= tag_q[set_idx][p-1];
          vld_q[set_idx][p] <= vld_q[set_idx][p-1];
        end
      end
      tag_q[set_idx][0] <= tag;
      vld_q[set_idx][0] <= 1'b1;
    end
  end

  // R5 R6
  head_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (vld_q[set_idx][0] && (tag_q[set_idx][0] == tag)));

  // R4
  clr_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !hit_o);

endmodule

// File: rtl/lru_cnt_bank.sv
module lru_cnt_bank #(
  parameter int LEVELS = 3,
  parameter int NA     = 3,
  parameter int CNT_W  = 32,
  localparam int N     = LEVELS * NA,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ASC_W = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [N-1:0]     inc_i,
  input  logic [LVL_W-1:0] rd_level_i,
  input  logic [ASC_W-1:0] rd_assoc_i,
  output logic [CNT_W-1:0] rd_count_o
);

  logic [CNT_W-1:0] cnt_q [N];

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        cnt_q[i] <= '0;
      else if (clr_i)                     cnt_q[i] <= '0;
      else if (inc_i[i] && ~&cnt_q[i])    cnt_q[i] <= cnt_q[i] + 1'b1;
    end

    // R7
    sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (&cnt_q[i] && !clr_i) |=> &cnt_q[i]);

    // R8
    clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q[i] == '0));

    // R7
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (cnt_q[i] >= $past(cnt_q[i])));
  end

  for (genvar k = 0; k < LEVELS; k++) begin : g_incl
    for (genvar j = 0; j + 1 < NA; j++) begin : g_pair
      // R11
      incl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q[k*NA+j+1] <= cnt_q[k*NA+j]);
    end
  end

  always_comb begin
    rd_count_o = '0;
    if (int'(rd_level_i) < LEVELS && int'(rd_assoc_i) < NA)
      rd_count_o = cnt_q[int'(rd_level_i) * NA + int'(rd_assoc_i)];
  end

endmodule

// File: rtl/lru_miss_profiler.sv
module lru_miss_profiler #(
  parameter int ADDR_W = 16,
  parameter int MMIN   = 1,
  parameter int MMAX   = 3,
  parameter int AMAX   = 4,
  parameter int OFS    = 0,
  parameter int CNT_W  = 32,
  localparam int LEVELS = MMAX - MMIN + 1,
  localparam int NA     = $clog2(AMAX) + 1,
  localparam int LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
  localparam int ASC_W  = (NA > 1) ? $clog2(NA) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              addr_valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              addr_ready_o,
  input  logic [LVL_W-1:0]  rd_level_i,
  input  logic [ASC_W-1:0]  rd_assoc_i,
  output logic [CNT_W-1:0]  rd_count_o
);

  localparam int LINE_W = ADDR_W - OFS;
  localparam int POS_W  = $clog2(AMAX);

  logic [LINE_W-1:0]    line;
  logic [LEVELS-1:0]    lvl_en;
  logic [LEVELS*NA-1:0] inc;

  lru_seq #(
    .LEVELS (LEVELS),
    .AW     (LINE_W)
  ) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_i),
    .valid_i  (addr_valid_i),
    .line_i   (addr_i[ADDR_W-1:OFS]),
    .ready_o  (addr_ready_o),
    .line_o   (line),
    .lvl_en_o (lvl_en)
  );

  for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
    logic             hit;
    logic [POS_W-1:0] pos;

    lru_level #(
      .AW   (LINE_W),
      .LVL  (k),
      .MMIN (MMIN),
      .AMAX (AMAX)
    ) u_level (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (lvl_en[k]),
      .line_i (line),
      .hit_o  (hit),
      .pos_o  (pos)
    );

    // hit at 0-based depth p misses in caches with 2^j <= p ways
    for (genvar j = 0; j < NA; j++) begin : g_way
      assign inc[k*NA+j] = lvl_en[k] & (~hit | (int'(pos) >= (1 << j)));
    end
  end

  lru_cnt_bank #(
    .LEVELS (LEVELS),
    .NA     (NA),
    .CNT_W  (CNT_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .inc_i      (inc),
    .rd_level_i (rd_level_i),
    .rd_assoc_i (rd_assoc_i),
    .rd_count_o (rd_count_o)
  );

  // R10
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(rd_level_i) >= LEVELS) |-> (rd_count_o == '0));

endmodule

// File: tb/tb_lru_miss_profiler.sv
module tb_lru_miss_profiler;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] addr = '0;
  logic        rdy;
  logic [1:0]  rd_lvl = '0;
  logic [1:0]  rd_asc = '0;
  logic [31:0] cnt;

  logic        vld2 = 1'b0;
  logic [15:0] addr2 = '0;
  logic        rdy2;
  logic [3:0]  cnt2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lru_miss_profiler dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .addr_valid_i(vld), .addr_i(addr), .addr_ready_o(rdy),
    .rd_level_i(rd_lvl), .rd_assoc_i(rd_asc), .rd_count_o(cnt)
  );

  lru_miss_profiler #(.OFS(2), .CNT_W(4)) dut_sat (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
    .addr_valid_i(vld2), .addr_i(addr2), .addr_ready_o(rdy2),
    .rd_level_i(rd_lvl), .rd_assoc_i(rd_asc), .rd_count_o(cnt2)
  );

  // age-stamp LRU model, one cache per (level, log2 ways)
  int m_tag [3][3][8][4];
  bit m_vld [3][3][8][4];
  int m_age [3][3][8][4];
  int m_cnt [3][3];
  int tnow;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 3; j++) begin
        m_cnt[k][j] = 0;
        for (int s = 0; s < 8; s++)
          for (int w = 0; w < 4; w++) begin
            m_vld[k][j][s][w] = 1'b0;
            m_age[k][j][s][w] = 0;
            m_tag[k][j][s][w] = 0;
          end
      end
  endtask

  task automatic model_access(input int wa);
    int s, tg, ways, hw, vic;
    tnow++;
    for (int k = 0; k < 3; k++) begin
      s  = wa & ((2 << k) - 1);
      tg = wa >> (k + 1);
      for (int j = 0; j < 3; j++) begin
        ways = 1 << j;
        hw = -1;
        for (int w = 0; w < ways; w++)
          if (m_vld[k][j][s][w] && m_tag[k][j][s][w] == tg) hw = w;
        if (hw >= 0) m_age[k][j][s][hw] = tnow;
        else begin
          vic = -1;
          for (int w = 0; w < ways; w++)
            if (!m_vld[k][j][s][w] && vic < 0) vic = w;
          if (vic < 0) begin
            vic = 0;
            for (int w = 1; w < ways; w++)
              if (m_age[k][j][s][w] < m_age[k][j][s][vic]) vic = w;
          end
          m_vld[k][j][s][vic] = 1'b1;
          m_tag[k][j][s][vic] = tg;
          m_age[k][j][s][vic] = tnow;
          m_cnt[k][j]++;
        end
      end
    end
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < 3; k++)
      for (int j = 0; j < 3; j++) begin
        rd_lvl = 2'(k); rd_asc = 2'(j);
        #1;
        chk(cnt == 32'(m_cnt[k][j]), req, int'(cnt), m_cnt[k][j]);
      end
  endtask

  task automatic send(input logic [15:0] a);
    int n;
    @(negedge clk);
    while (!rdy) @(negedge clk);
    vld = 1'b1; addr = a;
    @(negedge clk);
    vld = 1'b0;
    n = 0;
    while (!rdy && n < 20) begin n++; @(negedge clk); end
    // R2: busy exactly three cycles
    chk(n == 3, "R2 busy length", n, 3);
    model_access(int'(a));
  endtask

  task automatic send2(input logic [15:0] a);
    @(negedge clk);
    while (!rdy2) @(negedge clk);
    vld2 = 1'b1; addr2 = a;
    @(negedge clk);
    vld2 = 1'b0;
    while (!rdy2) @(negedge clk);
  endtask

  logic [15:0] lfsr = 16'hACE1;
  function automatic logic [15:0] nxt(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    tnow = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rdy == 1'b1, "R1 ready after reset", int'(rdy), 1);
    check_all("R1 counters zero");

    // R4: first access misses everywhere
    send(16'h0000);
    check_all("R4 first access");
    // R5: repeat costs nothing
    send(16'h0000);
    check_all("R5 repeat");

    // R5 R6: same set at every level, stride 8
    send(16'd8); send(16'd16); send(16'd24); send(16'd0);
    check_all("R6 conflict fill");
    send(16'd8); send(16'd24); send(16'd40); send(16'd16);
    check_all("R5 depth hits");

    // R3 R11: dense traffic in a small window
    for (int i = 0; i < 400; i++) begin
      lfsr = nxt(lfsr);
      send({10'd0, lfsr[5:0]});
      if (i % 50 == 49) check_all("R3 dense sweep");
    end
    // R3: wide tags
    for (int i = 0; i < 100; i++) begin
      lfsr = nxt(lfsr);
      send(lfsr);
      if (i % 25 == 24) check_all("R3 wide sweep");
    end

    // R10: out-of-range reads
    rd_lvl = 2'd3; rd_asc = 2'd0; #1;
    chk(cnt == 32'd0, "R10 level out of range", int'(cnt), 0);
    rd_lvl = 2'd0; rd_asc = 2'd3; #1;
    chk(cnt == 32'd0, "R10 assoc out of range", int'(cnt), 0);

    // R8: clear with a concurrent offer drops it
    @(negedge clk);
    clr = 1'b1; vld = 1'b1; addr = 16'd5;
    @(negedge clk);
    clr = 1'b0; vld = 1'b0;
    chk(rdy == 1'b1, "R8 offer dropped", int'(rdy), 1);
    model_reset();
    check_all("R8 clear zeroes");
    // R4: previously stored address misses after clear
    send(16'd0);
    check_all("R4 miss after clear");

    // R8: clear during an address in progress
    @(negedge clk);
    vld = 1'b1; addr = 16'd7;
    @(negedge clk);
    vld = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(rdy == 1'b1, "R8 abort idle", int'(rdy), 1);
    model_reset();
    check_all("R8 abort zeroes");
    send(16'd7);
    check_all("R8 after abort");

    // R9: OFS=2 instance, one line of four bytes
    send2(16'd0); send2(16'd1); send2(16'd2); send2(16'd3);
    rd_lvl = 2'd0; rd_asc = 2'd0; #1;
    chk(cnt2 == 4'd1, "R9 same line", int'(cnt2), 1);
    rd_lvl = 2'd2; rd_asc = 2'd2; #1;
    chk(cnt2 == 4'd1, "R9 same line deep", int'(cnt2), 1);
    // R7: alternate two conflicting lines, direct-mapped saturates
    for (int i = 0; i < 10; i++) begin
      send2(16'd32); send2(16'd0);
    end
    rd_lvl = 2'd0; rd_asc = 2'd0; #1;
    chk(cnt2 == 4'd15, "R7 saturate", int'(cnt2), 15);
    rd_lvl = 2'd0; rd_asc = 2'd1; #1;
    chk(cnt2 == 4'd2, "R7 two-way unaffected", int'(cnt2), 2);
    rd_lvl = 2'd0; rd_asc = 2'd2; #1;
    chk(cnt2 == 4'd2, "R11 four-way", int'(cnt2), 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule